// File: doc/BRIEF.md
# Large Payload Message Segmenter

This block breaks one long configuration payload into a series of mailbox transactions. Each transaction carries a 32-bit primary header word, a 32-bit extension word, and the byte offset and length of one slice of the payload. A slice is never longer than a fixed window, set by a parameter. The block only produces the headers and the slice offset and length. The payload bytes are moved elsewhere.

A start strobe captures the following inputs:

- the total payload size
- an 8-bit parameter ID
- a 16-bit module ID
- an 8-bit instance ID

The block then presents the first chunk and holds it until the mailbox side acknowledges it. It issues the next chunk only after that acknowledge. An error flag at any chunk abandons the whole sequence. A one-cycle done pulse follows the acknowledge of the last chunk. A zero-size request produces the done pulse with no chunk at all.

Top module: `cfg_segmenter`

## Requirements
- R1: After reset, `chunk_vld_o` and `done_o` are 0.
- R2: While a chunk is valid, the primary word has these fields:
  - bits 15:0 hold the module ID
  - bits 23:16 hold the instance ID
  - bits 28:24 hold the type code 4
  - bit 29 is 0 (request)
  - bits 31:30 are 2'b01 (module target)
- R3: Each chunk length equals the smaller of the remaining byte count and `WIN_BYTES`. The length is never 0.
- R4: `chunk_off_o` is the byte offset of the chunk, which is the total size minus the remaining count. Extension bits 19:0 carry the total size on the first chunk and that offset on every later chunk.
- R5: Extension bits 27:20 carry the captured parameter ID on every chunk. Extension bits 31:30 are 0.
- R6: Extension bit 29 (initial) is 1 on the first chunk only.
- R7: Extension bit 28 (final) is 1 exactly on the chunk whose length equals the remaining byte count.
- R8: A chunk stays valid, with unchanged header, offset and length, until `ack_i` or `err_i` is seen on a clock edge. The next chunk appears in the cycle after the acknowledge.
- R9: `err_i` while a chunk is valid ends the sequence: `chunk_vld_o` drops in the next cycle and no done pulse follows. `err_i` takes priority over `ack_i`.
- R10: A start with a total size of 0 gives no chunk and a single done pulse in the cycle after the start.
- R11: A payload of at most `WIN_BYTES` gives one chunk with both the initial and final flags set.
- R12: `start_i` is ignored while a sequence is in progress.
- R13: `done_o` is a one-cycle pulse in the cycle after the final chunk is acknowledged, and it is never high together with `chunk_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (sampled when idle) |
| total_size_i | input | 20 | Total payload size in bytes |
| param_id_i | input | 8 | Parameter ID |
| module_id_i | input | 16 | Target module ID |
| inst_id_i | input | 8 | Target instance ID |
| ack_i | input | 1 | Current chunk's transaction completed |
| err_i | input | 1 | Current chunk's transaction failed |
| prim_o | output | 32 | Primary header word |
| ext_o | output | 32 | Extension header word |
| chunk_off_o | output | 20 | Byte offset of the current chunk |
| chunk_len_o | output | 13 | Byte length of the current chunk |
| chunk_vld_o | output | 1 | A chunk is presented |
| done_o | output | 1 | One-cycle pulse: sequence finished |

## Verification
The assertions assume the following about the inputs:

- `ack_i` and `err_i` are only meaningful while a chunk is valid.
- The mailbox side acknowledges each chunk with a single-cycle pulse.

The directed stimulus keeps within this. It raises `ack_i` or `err_i` for exactly one cycle, and only while `chunk_vld_o` is high. It drives `start_i` as a one-cycle pulse. It changes the ID and size inputs only alongside a start, except in the scenario that checks that a start during a sequence is ignored.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seg_state_e;

  localparam int SIZE_W = 20;
  localparam logic [4:0] MSG_LCFG_SET = 5'd4;
  localparam logic       TGT_MODULE   = 1'b1;
  localparam logic       DIR_REQUEST  = 1'b0;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int WIN_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] total_i,
  input  logic              ack_i,
  input  logic              err_i,
  output logic              busy_o,
  output logic              first_o,
  output logic              last_o,
  output logic [SIZE_W-1:0] rem_o,
  output logic [SIZE_W-1:0] total_o,
  output logic              load_o,
  output logic              done_o
);
  localparam logic [SIZE_W-1:0] WIN = SIZE_W'(WIN_BYTES);

  seg_state_e        state_q, state_d;
  logic [SIZE_W-1:0] rem_q, rem_d, total_q, total_d;
  logic              first_q, first_d, done_q, done_d;
  logic              last;

  assign last = (rem_q <= WIN);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    total_d = total_q;
    first_d = first_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          total_d = total_i;
          rem_d   = total_i;
          first_d = 1'b1;
          if (total_i == '0) done_d  = 1'b1;
          else               state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (err_i) begin
          state_d = ST_IDLE;
        end else if (ack_i) begin
          first_d = 1'b0;
          if (last) begin
            state_d = ST_IDLE;
            rem_d   = '0;
            done_d  = 1'b1;
          end else begin
            rem_d = rem_q - WIN;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      total_q <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      total_q <= total_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q == ST_SEND);
  assign first_o = first_q;
  assign last_o  = last;
  assign rem_o   = rem_q;
  assign total_o = total_q;
  assign done_o  = done_q;

  // R9: a failed transaction returns the control to idle
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && err_i) |=> !busy_o);

  // R8: remaining count is frozen while waiting for completion
  assert_rem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack_i && !err_i) |=> $stable(rem_q));
endmodule

// File: rtl/seg_hdr_fmt.sv
module seg_hdr_fmt
  import seg_pkg::*;
#(
  parameter int WIN_BYTES = 4096,
  parameter int LEN_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [7:0]        param_i,
  input  logic [15:0]       module_i,
  input  logic [7:0]        inst_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [SIZE_W-1:0] total_i,
  input  logic [SIZE_W-1:0] rem_i,
  output logic [31:0]       prim_o,
  output logic [31:0]       ext_o,
  output logic [SIZE_W-1:0] off_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [7:0]  param_q;
  logic [15:0] module_q;
  logic [7:0]  inst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      param_q  <= '0;
      module_q <= '0;
      inst_q   <= '0;
    end else if (load_i) begin
      param_q  <= param_i;
      module_q <= module_i;
      inst_q   <= inst_i;
    end
  end

  logic [SIZE_W-1:0] off;

  always_comb begin
    off    = total_i - rem_i;
    len_o  = last_i ? rem_i[LEN_W-1:0] : LEN_W'(WIN_BYTES);
    off_o  = off;
    prim_o = {1'b0, TGT_MODULE, DIR_REQUEST, MSG_LCFG_SET, inst_q, module_q};
    ext_o  = {2'b00, first_i, last_i, param_q, (first_i ? total_i : off)};
  end
endmodule

// File: rtl/cfg_segmenter.sv
module cfg_segmenter
  import seg_pkg::*;
#(
  parameter int WIN_BYTES = 4096,
  parameter int LEN_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] total_size_i,
  input  logic [7:0]        param_id_i,
  input  logic [15:0]       module_id_i,
  input  logic [7:0]        inst_id_i,
  input  logic              ack_i,
  input  logic              err_i,
  output logic [31:0]       prim_o,
  output logic [31:0]       ext_o,
  output logic [SIZE_W-1:0] chunk_off_o,
  output logic [LEN_W-1:0]  chunk_len_o,
  output logic              chunk_vld_o,
  output logic              done_o
);
  logic              rst_sync_n;
  logic              busy, first, last, load;
  logic [SIZE_W-1:0] rem, total;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_ctrl #(.WIN_BYTES(WIN_BYTES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .total_i (total_size_i),
    .ack_i   (ack_i),
    .err_i   (err_i),
    .busy_o  (busy),
    .first_o (first),
    .last_o  (last),
    .rem_o   (rem),
    .total_o (total),
    .load_o  (load),
    .done_o  (done_o)
  );

  seg_hdr_fmt #(.WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .param_i  (param_id_i),
    .module_i (module_id_i),
    .inst_i   (inst_id_i),
    .first_i  (first),
    .last_i   (last),
    .total_i  (total),
    .rem_i    (rem),
    .prim_o   (prim_o),
    .ext_o    (ext_o),
    .off_o    (chunk_off_o),
    .len_o    (chunk_len_o)
  );

  assign chunk_vld_o = busy;

  // R3: chunk length is nonzero and within the window
  assert_len_bounds_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chunk_vld_o |-> (chunk_len_o != '0 && chunk_len_o <= LEN_W'(WIN_BYTES)));

  // R6: the initial flag only appears at offset zero
  assert_init_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chunk_vld_o && ext_o[29]) |-> (chunk_off_o == '0));

  // R8: chunk held stable until completion
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chunk_vld_o && !ack_i && !err_i) |=>
      (chunk_vld_o && $stable(ext_o) && $stable(prim_o) && $stable(chunk_len_o)));

  // R9: error ends the sequence without a done pulse
  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chunk_vld_o && err_i) |=> (!chunk_vld_o && !done_o));

  // R13: done never overlaps a valid chunk
  assert_done_excl_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !chunk_vld_o);

  // R5: parameter ID constant across consecutive chunks
  assert_param_const_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chunk_vld_o && $past(chunk_vld_o)) |-> (ext_o[27:20] == $past(ext_o[27:20])));
endmodule

// File: tb/cfg_segmenter_bench.sv
module cfg_segmenter_bench;
  localparam int WIN = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [19:0] total_size_i = '0;
  logic [7:0]  param_id_i = '0;
  logic [15:0] module_id_i = '0;
  logic [7:0]  inst_id_i = '0;
  logic        ack_i = 1'b0;
  logic        err_i = 1'b0;
  logic [31:0] prim_o, ext_o;
  logic [19:0] chunk_off_o;
  logic [12:0] chunk_len_o;
  logic        chunk_vld_o, done_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_segmenter u_cfg_segmenter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_size_i(total_size_i),
    .param_id_i(param_id_i), .module_id_i(module_id_i), .inst_id_i(inst_id_i),
    .ack_i(ack_i), .err_i(err_i), .prim_o(prim_o), .ext_o(ext_o),
    .chunk_off_o(chunk_off_o), .chunk_len_o(chunk_len_o),
    .chunk_vld_o(chunk_vld_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic kick(input int size, input int pid, input int mid, input int iid);
    start_i = 1'b1; total_size_i = 20'(size); param_id_i = 8'(pid);
    module_id_i = 16'(mid); inst_id_i = 8'(iid);
    tick();
    start_i = 1'b0;
  endtask

  task automatic check_chunk(input int size, input int off, input int pid,
                             input int mid, input int iid);
    int rem = size - off;
    int len = (rem > WIN) ? WIN : rem;
    bit first = (off == 0);
    bit fin = (len == rem);
    logic [31:0] ep = {2'b01, 1'b0, 5'd4, 8'(iid), 16'(mid)};
    logic [31:0] ee = {2'b00, first, fin, 8'(pid), 20'(first ? size : off)};
    chk(chunk_vld_o == 1'b1, "R8 chunk valid", chunk_vld_o, 1);
    chk(prim_o == ep, "R2 primary word", prim_o, ep);
    chk(chunk_len_o == 13'(len), "R3 chunk length", chunk_len_o, len);
    chk(chunk_off_o == 20'(off), "R4 chunk offset", chunk_off_o, off);
    chk(ee[19:0] == ext_o[19:0], "R4 ext size/offset", ext_o[19:0], ee[19:0]);
    chk(ext_o[31:20] == ee[31:20], "R5 R6 R7 ext flags/param", ext_o[31:20], ee[31:20]);
  endtask

  task automatic ack_one();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  task automatic run_full(input int size, input int pid, input int mid, input int iid,
                          input int nchk);
    int off = 0;
    int n = 0;
    kick(size, pid, mid, iid);
    while (off < size) begin
      if (n < nchk || size - off <= WIN) check_chunk(size, off, pid, mid, iid);
      off += (size - off > WIN) ? WIN : size - off;
      n++;
      ack_one();
      if (off < size) chk(done_o == 1'b0, "R13 no early done", done_o, 0);
    end
    chk(done_o == 1'b1 && chunk_vld_o == 1'b0, "R13 done pulse", {done_o, chunk_vld_o}, 2'b10);
    tick();
    chk(done_o == 1'b0, "R13 done one cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(chunk_vld_o == 1'b0, "R1 reset valid", chunk_vld_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
  endtask

  task automatic t_zero();
    kick(0, 8'h11, 16'h0001, 8'h02);
    chk(done_o == 1'b1 && chunk_vld_o == 1'b0, "R10 zero size done", {done_o, chunk_vld_o}, 2'b10);
    tick();
    chk(done_o == 1'b0 && chunk_vld_o == 1'b0, "R10 zero size quiet", {done_o, chunk_vld_o}, 0);
  endtask

  task automatic t_hold();
    kick(9000, 8'h5A, 16'h1234, 8'h07);
    for (int i = 0; i < 4; i++) check_chunk(9000, 0, 8'h5A, 16'h1234, 8'h07);
    ack_one();
    for (int i = 0; i < 3; i++) check_chunk(9000, WIN, 8'h5A, 16'h1234, 8'h07);
    ack_one();
    check_chunk(9000, 2 * WIN, 8'h5A, 16'h1234, 8'h07);
    ack_one();
    chk(done_o == 1'b1, "R8 done after third ack", done_o, 1);
    tick();
  endtask

  task automatic t_error();
    kick(10000, 8'hC3, 16'hBEEF, 8'h10);
    ack_one();
    check_chunk(10000, WIN, 8'hC3, 16'hBEEF, 8'h10);
    err_i = 1'b1; ack_i = 1'b1; tick(); err_i = 1'b0; ack_i = 1'b0;
    chk(chunk_vld_o == 1'b0, "R9 stop on error", chunk_vld_o, 0);
    chk(done_o == 1'b0, "R9 no done on error", done_o, 0);
    tick(); tick();
    chk(chunk_vld_o == 1'b0 && done_o == 1'b0, "R9 stays idle", {chunk_vld_o, done_o}, 0);
  endtask

  task automatic t_busy_start();
    kick(8200, 8'h22, 16'h0F0F, 8'h33);
    start_i = 1'b1; total_size_i = 20'd5; param_id_i = 8'h99;
    module_id_i = 16'h7777; inst_id_i = 8'h44;
    tick();
    start_i = 1'b0;
    check_chunk(8200, 0, 8'h22, 16'h0F0F, 8'h33);
    ack_one();
    check_chunk(8200, WIN, 8'h22, 16'h0F0F, 8'h33);
    chk(chunk_off_o == 20'd4096, "R12 start ignored while busy", chunk_off_o, 4096);
    ack_one();
    check_chunk(8200, 2 * WIN, 8'h22, 16'h0F0F, 8'h33);
    ack_one();
    chk(done_o == 1'b1, "R12 sequence completes", done_o, 1);
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_zero();
    run_full(100, 8'hA1, 16'h0102, 8'h03, 4);       // R11 single short chunk
    run_full(WIN, 8'hA2, 16'hFFFF, 8'hFF, 4);       // R11 exactly one window
    run_full(WIN + 1, 8'hA3, 16'h0000, 8'h00, 4);   // R7 one-byte tail
    run_full(10000, 8'hA4, 16'h4321, 8'h09, 4);     // R3 R4 three chunks
    t_hold();
    t_error();
    t_busy_start();
    run_full(20'hFFFFF, 8'hFE, 16'h8001, 8'h80, 3); // R4 R7 largest size
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule